// File: doc/BRIEF.md
# Three-Level Inverter Gate Drive Stage with Dead Time and Overcurrent Trip

This block sits between a three-level space-vector modulator and the gate drivers of a diode-clamped three-phase inverter. It takes twelve ideal switch commands, four per phase leg, and returns twelve drive signals. A rising command reaches its switch only after a programmable dead time. A falling command takes its switch off on the next clock edge. The two switches of each complementary pair in a leg never conduct together.

A two-bit selector chooses one of four operating settings. Each setting fixes both the switching period and the dead time. The block keeps a carrier counter that steps through the chosen period. A new setting takes effect only when that counter wraps, so a period is never cut short.

All timing runs on a tick of one tenth of a microsecond, made from the system clock by a prescaler. An overcurrent input blanks every output at once, without waiting for a clock edge. The same input sets a trip latch. The latch holds the outputs off until software clears it, or until reset.

Top module: `npc_gate_stage`

## Requirements
- R1: While and after a synchronous reset, all twelve gate outputs are low, the trip flag is low, the carrier reads 0, and the period output shows the period of the setting on the selector during reset.
- R2: All counting is in ticks, and one tick lasts TICK_DIV clock cycles. The first tick falls on the TICK_DIV-th cycle after reset.
- R3: Channel c is qualified while its command is high, its partner's command is low and no trip is active. When channel c becomes qualified, its counter loads the dead time. The counter drops by one on each tick. The output goes high on the clock edge after the counter has reached 0, provided the channel is still qualified.
- R4: A gate output goes low on the first clock edge at which its channel is no longer qualified.
- R5: A command that stays high for less than the dead time never produces an output pulse.
- R6: Channels form complementary pairs within each leg. Channel 4L+k pairs with channel 4L+(k XOR 2), so switch 1 pairs with switch 3 and switch 2 pairs with switch 4. When both commands of a pair are high, neither output turns on, and the two outputs of a pair are never high together.
- R7: The selector values 0, 1, 2 and 3 give periods of 200, 160, 100 and 60 ticks and dead times of 20, 16, 10 and 6 ticks.
- R8: The selector is sampled only during reset and at the tick on which the carrier wraps. A change at any other time shows up on the period output only after the next wrap.
- R9: The carrier advances by one on each tick, from 0 up to period-1, and then returns to 0.
- R10: While the trip input is high, all gate outputs are low in the same cycle, without waiting for a clock edge.
- R11: A high trip input sets the trip flag on the next edge. The flag stays set until an edge at which the clear input is high and the trip input is low.
- R12: While the trip flag is set, all gate outputs stay low. After it clears, a command that is still high must wait a full dead time again before its output turns on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_sel | input | 2 | Operating setting selector (period and dead time) |
| gate_cmd | input | 12 | Ideal switch commands, channel 4L+k is switch k+1 of leg L |
| trip_in | input | 1 | Overcurrent trip request, active high |
| trip_clr | input | 1 | Clears the trip latch when the trip input is low |
| gate_out | output | 12 | Dead-time corrected drive signals |
| trip_active | output | 1 | Trip latch state |
| carrier | output | 8 | Carrier position in ticks within the current period |
| period_len | output | 8 | Period of the active setting in ticks |

## Verification
The channel outputs are registered once. A falling or blocked command therefore appears on the pins one edge later. A rising command appears one edge after its counter reaches zero, which is dead time × TICK_DIV plus the tick phase after the qualifying edge. The trip blanking is combinational and is seen in the same cycle. The trip flag, carrier and period output update on the edge that samples their cause. The bench advances a behavioural model at each rising edge, drives inputs at the falling edge and compares all outputs three time units later, so every result is read after the edge it depends on and before the next one.

// File: rtl/npc_dt_pkg.sv
package npc_dt_pkg;

    localparam int CNT_W   = 8;
    localparam int SEL_W   = 2;
    localparam int NUM_SET = 4;
    localparam int LEG_SW  = 4;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [SEL_W-1:0] sel_t;

    typedef struct packed {
        cnt_t period;
        cnt_t dead;
    } timing_t;

    typedef enum logic {
        TRIP_CLEAR = 1'b0,
        TRIP_HELD  = 1'b1
    } trip_e;

    typedef struct packed {
        logic qual_d;
        cnt_t remain;
        logic drive;
    } chan_t;

    // period and dead time for each selector value, in ticks
    function automatic timing_t timing_of(sel_t s);
        timing_t t;
        case (s)
            2'd0:    begin t.period = cnt_t'(200); t.dead = cnt_t'(20); end
            2'd1:    begin t.period = cnt_t'(160); t.dead = cnt_t'(16); end
            2'd2:    begin t.period = cnt_t'(100); t.dead = cnt_t'(10); end
            default: begin t.period = cnt_t'(60);  t.dead = cnt_t'(6);  end
        endcase
        return t;
    endfunction

    // complementary partner inside a leg: switch 1<->3, 2<->4
    function automatic int partner_of(int ch);
        return (ch / LEG_SW) * LEG_SW + ((ch % LEG_SW) ^ 2);
    endfunction

endpackage

// File: rtl/npc_tick_gen.sv
module npc_tick_gen #(
    parameter int TICK_DIV = 10
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [W-1:0] phase;

    generate
        if (TICK_DIV > 1) begin : g_div
            assign tick = (phase == W'(TICK_DIV - 1));
            always_ff @(posedge clk) begin
                if (rst)       phase <= '0;
                else if (tick) phase <= '0;
                else           phase <= phase + 1'b1;
            end
        end else begin : g_pass
            assign tick = 1'b1;
            always_ff @(posedge clk) phase <= '0;
        end
    endgenerate
endmodule

// File: rtl/npc_period_sel.sv
module npc_period_sel
    import npc_dt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  sel_t    freq_sel,
    output timing_t cur,
    output cnt_t    carrier
);
    sel_t sel_q;
    logic wrap;

    assign cur  = timing_of(sel_q);
    assign wrap = (carrier >= cur.period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            carrier <= '0;
            sel_q   <= freq_sel;
        end else if (tick) begin
            if (wrap) begin
                carrier <= '0;
                sel_q   <= freq_sel;
            end else begin
                carrier <= carrier + 1'b1;
            end
        end
    end
endmodule

// File: rtl/npc_trip_latch.sv
module npc_trip_latch
    import npc_dt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trip_in,
    input  logic trip_clr,
    output logic held,
    output logic block
);
    trip_e state;

    assign held  = (state == TRIP_HELD);
    assign block = held | trip_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TRIP_CLEAR;
        end else begin
            case (state)
                TRIP_CLEAR: if (trip_in) state <= TRIP_HELD;
                TRIP_HELD:  if (trip_clr && !trip_in) state <= TRIP_CLEAR;
                default:    state <= TRIP_HELD;
            endcase
        end
    end
endmodule

// File: rtl/npc_dt_channel.sv
module npc_dt_channel
    import npc_dt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cmd_self,
    input  logic cmd_partner,
    input  logic block,
    input  cnt_t dead,
    output logic drive
);
    chan_t st;
    logic  qual;
    logic  rise;

    assign qual  = cmd_self & ~cmd_partner & ~block;
    assign rise  = qual & ~st.qual_d;
    assign drive = st.drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.qual_d <= qual;
            if (!qual) begin
                st.drive <= 1'b0;
            end else if (rise) begin
                st.remain <= dead;
                st.drive  <= 1'b0;
            end else if (st.remain == '0) begin
                st.drive <= 1'b1;
            end else if (tick) begin
                st.remain <= st.remain - 1'b1;
            end
        end
    end
endmodule

// File: rtl/npc_gate_stage.sv
module npc_gate_stage
    import npc_dt_pkg::*;
#(
    parameter int N_LEG    = 3,
    parameter int TICK_DIV = 10,
    localparam int N_CH    = N_LEG * LEG_SW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      freq_sel,
    input  logic [N_CH-1:0] gate_cmd,
    input  logic            trip_in,
    input  logic            trip_clr,
    output logic [N_CH-1:0] gate_out,
    output logic            trip_active,
    output logic [7:0]      carrier,
    output logic [7:0]      period_len
);
    logic            tick;
    logic            block;
    timing_t         cur;
    cnt_t            carrier_q;
    logic [N_CH-1:0] drive;

    npc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    npc_period_sel u_period (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .freq_sel (freq_sel),
        .cur      (cur),
        .carrier  (carrier_q)
    );

    npc_trip_latch u_trip (
        .clk      (clk),
        .rst      (rst),
        .trip_in  (trip_in),
        .trip_clr (trip_clr),
        .held     (trip_active),
        .block    (block)
    );

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            npc_dt_channel u_ch (
                .clk         (clk),
                .rst         (rst),
                .tick        (tick),
                .cmd_self    (gate_cmd[c]),
                .cmd_partner (gate_cmd[partner_of(c)]),
                .block       (block),
                .dead        (cur.dead),
                .drive       (drive[c])
            );
        end
    endgenerate

    // trip input blanks outputs without waiting for an edge
    assign gate_out   = drive & {N_CH{~block}};
    assign carrier    = 8'(carrier_q);
    assign period_len = 8'(cur.period);
endmodule

// File: rtl/npc_gate_stage_chk.sv
module npc_gate_stage_chk #(
    parameter int N_CH = 12
) (
    input logic            clk,
    input logic            rst,
    input logic [N_CH-1:0] gate_cmd,
    input logic            trip_in,
    input logic            trip_clr,
    input logic [N_CH-1:0] gate_out,
    input logic            trip_active,
    input logic [7:0]      carrier,
    input logic [7:0]      period_len
);
    // R10
    trip_blank_chk: assert property (@(posedge clk) disable iff (rst)
        trip_in |-> (gate_out == '0));

    // R12
    held_blank_chk: assert property (@(posedge clk) disable iff (rst)
        trip_active |-> (gate_out == '0));

    // R11
    trip_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (trip_active && !(trip_clr && !trip_in)) |=> trip_active);

    // R11
    trip_set_chk: assert property (@(posedge clk) disable iff (rst)
        trip_in |=> trip_active);

    // R9
    carrier_range_chk: assert property (@(posedge clk) disable iff (rst)
        carrier < period_len);

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_a
            localparam int P = (c / 4) * 4 + ((c % 4) ^ 2);
            // R6
            pair_excl_chk: assert property (@(posedge clk) disable iff (rst)
                !(gate_out[c] && gate_out[P]));
            // R4
            fast_off_chk: assert property (@(posedge clk) disable iff (rst)
                (!gate_cmd[c] || gate_cmd[P]) |=> !gate_out[c]);
            // R3
            on_qual_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(gate_out[c]) |-> ($past(gate_cmd[c]) && !$past(gate_cmd[P])));
        end
    endgenerate
endmodule

bind npc_gate_stage npc_gate_stage_chk #(.N_CH(N_CH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .gate_cmd    (gate_cmd),
    .trip_in     (trip_in),
    .trip_clr    (trip_clr),
    .gate_out    (gate_out),
    .trip_active (trip_active),
    .carrier     (carrier),
    .period_len  (period_len)
);

// File: tb/npc_gate_stage_tb.sv
module npc_gate_stage_tb;
    localparam int DIV  = 2;
    localparam int N_CH = 12;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      freq_sel = 2'd0;
    logic [N_CH-1:0] gate_cmd = '0;
    logic            trip_in = 1'b0;
    logic            trip_clr = 1'b0;
    logic [N_CH-1:0] gate_out;
    logic            trip_active;
    logic [7:0]      carrier;
    logic [7:0]      period_len;

    int n_cmp = 0;
    int n_bad = 0;
    bit started = 0;
    bit done = 0;
    string req_tag = "R1";

    always #5 clk = ~clk;

    npc_gate_stage #(.N_LEG(3), .TICK_DIV(DIV)) u_dut (
        .clk (clk), .rst (rst), .freq_sel (freq_sel), .gate_cmd (gate_cmd),
        .trip_in (trip_in), .trip_clr (trip_clr), .gate_out (gate_out),
        .trip_active (trip_active), .carrier (carrier), .period_len (period_len)
    );

    // requirement tables R7
    int per_tab [4] = '{200, 160, 100, 60};
    int dt_tab  [4] = '{20, 16, 10, 6};

    // behavioural reference
    int m_tick, m_per, m_sel;
    bit m_lat;
    int m_left [N_CH];
    bit m_armed [N_CH];
    bit m_on [N_CH];

    always @(posedge clk) begin
        if (rst) begin
            m_tick = 0; m_per = 0; m_sel = int'(freq_sel); m_lat = 0;
            for (int c = 0; c < N_CH; c++) begin
                m_left[c] = 0; m_armed[c] = 0; m_on[c] = 0;
            end
        end else begin
            bit tk, blk;
            tk  = (m_tick == DIV - 1);
            blk = trip_in | m_lat;
            for (int c = 0; c < N_CH; c++) begin
                bit q;
                q = gate_cmd[c] & ~gate_cmd[c ^ 2] & ~blk;
                if (!q) m_on[c] = 0;
                else if (!m_armed[c]) begin m_left[c] = dt_tab[m_sel]; m_on[c] = 0; end
                else if (m_left[c] == 0) m_on[c] = 1;
                else if (tk) m_left[c] = m_left[c] - 1;
                m_armed[c] = q;
            end
            if (trip_in) m_lat = 1;
            else if (trip_clr) m_lat = 0;
            if (tk) begin
                if (m_per >= per_tab[m_sel] - 1) begin m_per = 0; m_sel = int'(freq_sel); end
                else m_per = m_per + 1;
            end
            m_tick = tk ? 0 : m_tick + 1;
        end
        started = 1;
    end

    task automatic check(string what, string rq, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", rq, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        #3;
        if (started && !done) begin
            logic [N_CH-1:0] exp_g;
            for (int c = 0; c < N_CH; c++)
                exp_g[c] = m_on[c] & ~(trip_in | m_lat);
            check("gate_out", req_tag, int'(gate_out), int'(exp_g));
            check("trip_active", req_tag, int'(trip_active), int'(m_lat));
            check("carrier", req_tag, int'(carrier), m_per);
            check("period_len", req_tag, int'(period_len), per_tab[m_sel]);
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        wait_cyc(4);
        #3;
        // R1 reset state
        check("reset gates", "R1", int'(gate_out), 0);
        check("reset carrier", "R1", int'(carrier), 0);
        check("reset period", "R1", int'(period_len), 200);
        @(negedge clk);
        rst = 1'b0;

        // R2 R3 R7: switch 1 of leg 0, dead time 20 ticks = 40 cycles
        req_tag = "R3";
        gate_cmd = 12'h001;
        wait_cyc(38);
        #3 check("gate before dead time", "R3", int'(gate_out[0]), 0);
        wait_cyc(6);
        #3 check("gate after dead time", "R2", int'(gate_out[0]), 1);

        // R4 fast turn-off
        req_tag = "R4";
        @(negedge clk) gate_cmd = 12'h000;
        @(negedge clk);
        #3 check("gate off next edge", "R4", int'(gate_out[0]), 0);

        // R5 short pulse
        req_tag = "R5";
        @(negedge clk) gate_cmd = 12'h002;
        wait_cyc(25);
        gate_cmd = 12'h000;
        wait_cyc(60);
        #3 check("short pulse", "R5", int'(gate_out), 0);

        // R6 pair conflict, then swap
        req_tag = "R6";
        @(negedge clk) gate_cmd = 12'h005;
        wait_cyc(80);
        #3 check("both pair cmds", "R6", int'(gate_out), 0);
        @(negedge clk) gate_cmd = 12'h001;
        wait_cyc(60);
        @(negedge clk) gate_cmd = 12'h004;
        wait_cyc(60);
        #3 check("swapped pair", "R6", int'(gate_out), 12'h004);

        // R7 R8 R9 setting change only at wrap
        req_tag = "R8";
        @(negedge clk) freq_sel = 2'd3;
        wait_cyc(2);
        #3 check("no early switch", "R8", int'(period_len), 200);
        wait_cyc(420);
        #3 check("setting 3 period", "R7", int'(period_len), 60);
        req_tag = "R9";
        @(negedge clk) gate_cmd = 12'h810;
        wait_cyc(150);

        // R10 R11 R12 trip handling
        req_tag = "R10";
        @(negedge clk) trip_in = 1'b1;
        #3 check("trip blanks same cycle", "R10", int'(gate_out), 0);
        wait_cyc(3);
        req_tag = "R11";
        trip_clr = 1'b1;
        wait_cyc(2);
        trip_in = 1'b0; trip_clr = 1'b0;
        wait_cyc(20);
        #3 check("trip latched", "R11", int'(trip_active), 1);
        req_tag = "R12";
        @(negedge clk) trip_clr = 1'b1;
        @(negedge clk) trip_clr = 1'b0;
        wait_cyc(8);
        #3 check("re-arm dead time", "R12", int'(gate_out), 0);
        wait_cyc(20);
        #3 check("back on after clear", "R12", int'(gate_out), 12'h810);

        // mixed traffic over all settings
        req_tag = "R3 R6 R8";
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            gate_cmd = 12'($urandom);
            if (($urandom % 16) == 0) freq_sel = 2'($urandom);
            trip_in = (($urandom % 97) == 0);
            trip_clr = (($urandom % 5) == 0);
            wait_cyc(int'($urandom_range(1, 45)));
        end
        trip_in = 1'b0;
        wait_cyc(5);
        finish_run();
    end

    initial begin
        #1500000;
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end
endmodule